// File: doc/BRIEF.md
# Mode-Selected Four-Function ALU

This block is a combinational arithmetic-logic unit of parameterised width, assembled from one repeated bit cell. Two selects and a mode bit choose the operation. One select complements operand A. The other select lets operand B through or forces it to zero. The mode bit either blocks the carry chain, which gives a bitwise logic result, or lets it ripple, which gives an adder result. An external carry-in adds one to the arithmetic operations. Because of this, twelve distinct functions come from one cell equation, with no selection over separate function units.

The block suits a datapath that needs increment, negate, add, reverse subtract and the common bitwise operations at low cost. It has no clock and no state. The result and both flags settle one ripple delay after the inputs change.

Top module: `mode_alu`

## Requirements
- R1: With `arith_en`=0, `inv_a`=0 and `pass_b`=0, `result` equals `opnd_a`.
- R2: With `arith_en`=0, `inv_a`=1 and `pass_b`=0, `result` equals the bitwise complement of `opnd_a`.
- R3: With `arith_en`=0 and `pass_b`=1, `result` is `opnd_a` XOR `opnd_b` when `inv_a`=0 and XNOR when `inv_a`=1.
- R4: With `arith_en`=0, `carry_out` and `ovf` are 0 and `carry_in` has no effect on any output.
- R5: With `arith_en`=1 and `carry_in`=0, the {`pass_b`,`inv_a`} codes 00, 01, 10 and 11 give A, NOT A, A+B and (NOT A)+B, all modulo 2^WIDTH.
- R6: With `arith_en`=1 and `carry_in`=1, the same codes give A+1, the two's-complement negation of A, A+B+1 and B−A.
- R7: With `arith_en`=1, `carry_out` is bit WIDTH of the unsigned sum X+Y+`carry_in`. Here X is A, or NOT A when `inv_a`=1, and Y is B, or 0 when `pass_b`=0.
- R8: With `arith_en`=1, `ovf` is 1 exactly when X and Y have the same sign bit and `result` has a different one. This is the same as the carry into the top bit differing from the carry out of it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_a | input | WIDTH | Operand A |
| opnd_b | input | WIDTH | Operand B |
| pass_b | input | 1 | 1 lets B into each cell, 0 forces it to zero |
| inv_a | input | 1 | 1 complements A in each cell |
| arith_en | input | 1 | 1 lets carries ripple (arithmetic), 0 blocks them (logic) |
| carry_in | input | 1 | Carry into the lowest cell |
| result | output | WIDTH | Function result F |
| carry_out | output | 1 | Carry out of the top cell, 0 in logic mode |
| ovf | output | 1 | Signed overflow, 0 in logic mode |

## Verification
Each operand pair in the table is applied under all twelve select combinations. The corner pairs cover zero, all ones, the most negative and the most positive values. These values separate a carry that ripples the full width from one that stops early, and they separate a carry-out from a signed overflow. The alternating patterns 0x55 and 0xAA catch a swapped XOR/XNOR or an A/B mix-up bit by bit. Random pairs then cover general sums. Directed cases set `carry_in` in logic mode to confirm that it has no effect, and they hit each overflow direction at its boundary.

// File: rtl/mode_alu_pkg.sv
package mode_alu_pkg;
    typedef struct packed {
        logic inv_a;
        logic pass_b;
        logic arith_en;
    } alu_ctl_t;
endpackage

// File: rtl/alu_cell.sv
module alu_cell
    import mode_alu_pkg::*;
(
    input  logic     a_bit,
    input  logic     b_bit,
    input  alu_ctl_t ctl,
    input  logic     c_in,
    output logic     f_bit,
    output logic     c_out
);
    logic x_bit;
    logic y_bit;
    logic c_gated;

    always_comb begin
        x_bit   = ctl.inv_a ^ a_bit;
        y_bit   = ctl.pass_b & b_bit;
        c_gated = ctl.arith_en & c_in;
        f_bit   = x_bit ^ y_bit ^ c_gated;
        c_out   = (x_bit & y_bit) | (c_gated & (x_bit ^ y_bit));
    end
endmodule

// File: rtl/alu_cell_chain.sv
module alu_cell_chain
    import mode_alu_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] a_vec,
    input  logic [WIDTH-1:0] b_vec,
    input  alu_ctl_t         ctl,
    input  logic             c_first,
    output logic [WIDTH-1:0] f_vec,
    output logic [WIDTH:0]   carries
);
    assign carries[0] = c_first;

    for (genvar i = 0; i < WIDTH; i++) begin : g_cell
        alu_cell u_cell (
            .a_bit (a_vec[i]),
            .b_bit (b_vec[i]),
            .ctl   (ctl),
            .c_in  (carries[i]),
            .f_bit (f_vec[i]),
            .c_out (carries[i+1])
        );
    end
endmodule

// File: rtl/alu_flag_gen.sv
module alu_flag_gen (
    input  logic arith_en,
    input  logic c_into_top,
    input  logic c_out_top,
    output logic carry_flag,
    output logic ovf_flag
);
    always_comb begin
        carry_flag = arith_en & c_out_top;
        ovf_flag   = arith_en & (c_into_top ^ c_out_top);
    end
endmodule

// File: rtl/mode_alu.sv
module mode_alu
    import mode_alu_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] opnd_a,
    input  logic [WIDTH-1:0] opnd_b,
    input  logic             pass_b,
    input  logic             inv_a,
    input  logic             arith_en,
    input  logic             carry_in,
    output logic [WIDTH-1:0] result,
    output logic             carry_out,
    output logic             ovf
);
    localparam int TOP = WIDTH - 1;

    alu_ctl_t         ctl_d;
    logic [WIDTH:0]   carries;
    logic [WIDTH-1:0] f_d;

    always_comb begin
        ctl_d.inv_a    = inv_a;
        ctl_d.pass_b   = pass_b;
        ctl_d.arith_en = arith_en;
    end

    alu_cell_chain #(.WIDTH(WIDTH)) u_chain (
        .a_vec   (opnd_a),
        .b_vec   (opnd_b),
        .ctl     (ctl_d),
        .c_first (carry_in),
        .f_vec   (f_d),
        .carries (carries)
    );

    alu_flag_gen u_flags (
        .arith_en   (arith_en),
        .c_into_top (carries[TOP]),
        .c_out_top  (carries[WIDTH]),
        .carry_flag (carry_out),
        .ovf_flag   (ovf)
    );

    assign result = f_d;
endmodule

// File: rtl/mode_alu_chk.sv
module mode_alu_chk #(
    parameter int WIDTH = 8
) (
    input logic [WIDTH-1:0] opnd_a,
    input logic [WIDTH-1:0] opnd_b,
    input logic             pass_b,
    input logic             inv_a,
    input logic             arith_en,
    input logic             carry_in,
    input logic [WIDTH-1:0] result,
    input logic             carry_out,
    input logic             ovf
);
    logic [WIDTH-1:0] x_op;
    logic [WIDTH-1:0] y_op;
    logic [WIDTH:0]   wide_sum;

    always_comb begin
        x_op     = inv_a ? ~opnd_a : opnd_a;
        y_op     = pass_b ? opnd_b : '0;
        wide_sum = {1'b0, x_op} + {1'b0, y_op} + {{WIDTH{1'b0}}, carry_in};
        if (!arith_en && !pass_b && !inv_a)
            AST_LOGIC_PASS: assert (result == opnd_a) else $error("pass A"); // R1
        if (!arith_en && !pass_b && inv_a)
            AST_LOGIC_INVERT: assert (result == ~opnd_a) else $error("invert A"); // R2
        if (!arith_en && pass_b)
            AST_LOGIC_XOR: assert (result == (opnd_a ^ opnd_b ^ {WIDTH{inv_a}})) else $error("xor"); // R3
        if (!arith_en)
            AST_NO_LOGIC_FLAGS: assert (!carry_out && !ovf) else $error("flags in logic mode"); // R4
        if (arith_en)
            AST_ARITH_SUM: assert ({carry_out, result} == wide_sum) else $error("sum"); // R7
        if (arith_en)
            AST_SIGNED_OVF: assert (ovf == ((x_op[WIDTH-1] == y_op[WIDTH-1]) && (result[WIDTH-1] != x_op[WIDTH-1]))) else $error("ovf"); // R8
    end
endmodule

bind mode_alu mode_alu_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/mode_alu_tb.sv
module mode_alu_tb;
    localparam int W = 8;
    localparam int NPAIR = 14;
    localparam int WATCHDOG = 100000;

    localparam logic [15:0] PAIRS [0:NPAIR-1] = '{
        16'h0000, 16'hFFFF, 16'h8080, 16'h7F7F, 16'h7F01, 16'h8080,
        16'h80FF, 16'hFF01, 16'h55AA, 16'hAA55, 16'h0001, 16'h8000,
        16'h0080, 16'h7F80
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [W-1:0] opnd_a = '0, opnd_b = '0;
    logic pass_b = 1'b0, inv_a = 1'b0, arith_en = 1'b0, carry_in = 1'b0;
    logic [W-1:0] result;
    logic carry_out, ovf;
    int n_checks = 0;
    int n_errors = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    mode_alu #(.WIDTH(W)) u_dut (
        .opnd_a(opnd_a), .opnd_b(opnd_b), .pass_b(pass_b), .inv_a(inv_a),
        .arith_en(arith_en), .carry_in(carry_in),
        .result(result), .carry_out(carry_out), .ovf(ovf)
    );

    // reference: {ovf, carry, result} from the requirement table
    function automatic logic [W+1:0] model(input logic [W-1:0] a, input logic [W-1:0] b,
                                          input logic s1, input logic s0,
                                          input logic m, input logic c0);
        logic [W:0] s;
        logic [W-1:0] x, y;
        logic v;
        if (!m) begin
            case ({s1, s0})
                2'b00:   return {2'b00, a};
                2'b01:   return {2'b00, ~a};
                2'b10:   return {2'b00, a ^ b};
                default: return {2'b00, ~(a ^ b)};
            endcase
        end
        x = s0 ? ~a : a;
        y = s1 ? b : '0;
        case ({s1, s0, c0})
            3'b000: s = {1'b0, a};
            3'b010: s = {1'b0, ~a};
            3'b100: s = {1'b0, a} + {1'b0, b};
            3'b110: s = {1'b0, ~a} + {1'b0, b};
            3'b001: s = {1'b0, a} + 1;
            3'b011: s = {1'b0, ~a} + 1;
            3'b101: s = {1'b0, a} + {1'b0, b} + 1;
            default: s = {1'b0, ~a} + {1'b0, b} + 1;
        endcase
        v = (x[W-1] == y[W-1]) && (s[W-1] != x[W-1]);
        return {v, s};
    endfunction

    task automatic apply(input logic [W-1:0] a, input logic [W-1:0] b,
                         input logic s1, input logic s0, input logic m, input logic c0);
        @(negedge clk);
        opnd_a = a; opnd_b = b; pass_b = s1; inv_a = s0; arith_en = m; carry_in = c0;
        @(posedge clk);
        #2;
    endtask

    task automatic check(input string tag, input logic [W+1:0] got, input logic [W+1:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_errors++;
            $display("FAIL %s: got ovf/cout/result=%b/%b/%h expected %b/%b/%h",
                     tag, got[W+1], got[W], got[W-1:0], exp[W+1], exp[W], exp[W-1:0]);
        end
    endtask

    function automatic string tag_of(input logic s1, input logic s0, input logic m, input logic c0);
        if (!m) return (s1 ? "R3" : (s0 ? "R2" : "R1"));
        return c0 ? "R6/R7/R8" : "R5/R7/R8";
    endfunction

    task automatic run_all(input logic [W-1:0] a, input logic [W-1:0] b);
        for (int k = 0; k < 16; k++) begin
            logic [3:0] c;
            c = 4'(k);
            if (!c[1] && c[0]) continue; // logic mode, carry_in=1 covered in directed R4 tests
            apply(a, b, c[3], c[2], c[1], c[0]);
            check(tag_of(c[3], c[2], c[1], c[0]), {ovf, carry_out, result},
                  model(a, b, c[3], c[2], c[1], c[0]));
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > WATCHDOG && !done) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog: got cycles=%0d expected below %0d", cycles, WATCHDOG);
            finish_run();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        // initial state with all inputs zero: R1 pass of zero, R4 flags low
        check("R1 reset", {ovf, carry_out, result}, '0);
        rst_n = 1'b1;

        for (int p = 0; p < NPAIR; p++) run_all(PAIRS[p][15:8], PAIRS[p][7:0]);
        for (int r = 0; r < 40; r++) run_all(W'($urandom), W'($urandom));

        // R4: carry_in has no effect in logic mode
        for (int k = 0; k < 4; k++) begin
            apply(8'hFF, 8'hFF, k[1], k[0], 1'b0, 1'b1);
            check("R4 cin ignored", {ovf, carry_out, result}, model(8'hFF, 8'hFF, k[1], k[0], 1'b0, 1'b0));
        end
        // R6: negation of the most negative value wraps to itself with overflow
        apply(8'h80, 8'h00, 1'b0, 1'b1, 1'b1, 1'b1);
        check("R6 negate min", {ovf, carry_out, result}, {1'b1, 1'b0, 8'h80});
        // R6: B minus A, 3 - 5 = -2, no carry
        apply(8'h05, 8'h03, 1'b1, 1'b1, 1'b1, 1'b1);
        check("R6 b minus a", {ovf, carry_out, result}, {1'b0, 1'b0, 8'hFE});
        // R7: increment of all ones carries out, no overflow
        apply(8'hFF, 8'h00, 1'b0, 1'b0, 1'b1, 1'b1);
        check("R7 increment wrap", {ovf, carry_out, result}, {1'b0, 1'b1, 8'h00});
        // R8: positive overflow 0x7F+1, negative overflow 0x80+0xFF
        apply(8'h7F, 8'h01, 1'b1, 1'b0, 1'b1, 1'b0);
        check("R8 pos ovf", {ovf, carry_out, result}, {1'b1, 1'b0, 8'h80});
        apply(8'h80, 8'hFF, 1'b1, 1'b0, 1'b1, 1'b0);
        check("R8 neg ovf", {ovf, carry_out, result}, {1'b1, 1'b1, 8'h7F});
        // R5: A plus B exact value
        apply(8'h12, 8'h34, 1'b1, 1'b0, 1'b1, 1'b0);
        check("R5 add", {ovf, carry_out, result}, {1'b0, 1'b0, 8'h46});

        done = 1'b1;
        finish_run();
    end
endmodule